// File: doc/BRIEF.md
# Ultrasonic Ranging Trigger and Echo Capture

This block drives a pulse-echo ranging sensor on behalf of a processor. Software programs a trigger period and a trigger high time, both counted in system clocks, and sets an enable bit. From then on the block emits a short high pulse at the start of every period, with no further software action. A period of zero, or a cleared enable, keeps the trigger line low.

The echo return line is brought into the clock domain through a synchronizer and watched for edges in both directions. Every edge raises a level interrupt and records whether the echo went high or low. Software can therefore read the status register once to learn whether the echo pulse began or ended. The interrupt stays up until software acknowledges it. If a second edge arrives before that acknowledgement, an overrun flag records that an edge was missed.

Top module: `echo_ranger`

## Requirements
- R1: After reset the trigger and interrupt outputs are low and all four registers read as zero.
- R2: With the enable set, period P > 0 and high time H < P, the trigger is high for the first H clocks of every P-clock period and low for the rest. This repeats with no further writes, and the first high clock is the one right after the enable write.
- R3: A period of zero keeps the trigger low even while the enable bit is set.
- R4: Clearing the enable drives the trigger low in the next clock and resets the period count. A later enable starts again at the beginning of the high phase.
- R5: A rising echo edge sets the pending bit (status bit 1) and the polarity bit (status bit 0) to 1, and raises the interrupt on the third clock edge after the input change.
- R6: A falling echo edge sets the pending bit, raises the interrupt and sets the polarity bit to 0.
- R7: The interrupt and pending bit stay set until software writes 1 to bit 0 of the status register (address 3). Writing 0 there has no effect, and neither write alters the polarity bit.
- R8: An edge that arrives while the pending bit is set also sets the overrun bit (status bit 2). The status clear write clears it.
- R9: When an edge and a status clear fall in the same clock, the edge wins: pending is set, polarity follows the new edge, and overrun is cleared.
- R10: The register map is: address 0 holds the enable in bit 0, and the other bits read 0. Address 1 holds the 16-bit period and address 2 the 16-bit high time. Writes are captured on the clock edge where the write strobe is high, and reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| echo_i | input | 1 | Echo return line from the sensor, asynchronous |
| trig_o | output | 1 | Trigger pulse to the sensor |
| irq_o | output | 1 | Level interrupt, high while an echo edge is pending |

## Verification
Two functions can meet in the same cycle: a detected echo edge and a software acknowledge. To provoke this, a first edge is left pending. The echo line is then toggled, and the status clear strobe is timed so that it lands exactly on the third clock edge after the toggle, which is the edge where the new transition is registered. The result is judged by reading status afterwards. Pending must still be set, polarity must follow the new edge, and overrun must be clear. A separate case lets the same second edge arrive without the clear, to show that overrun is set there.

// File: rtl/ranger_pkg.sv
`timescale 1ns/1ps
package ranger_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    ADR_CTRL   = 2'd0,
    ADR_PERIOD = 2'd1,
    ADR_HIGH   = 2'd2,
    ADR_STATUS = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int STAT_CLR_BIT = 0;
  localparam int ST_POL_BIT   = 0;
  localparam int ST_PEND_BIT  = 1;
  localparam int ST_OVR_BIT   = 2;
endpackage

// File: rtl/ranger_trig.sv
`timescale 1ns/1ps
module ranger_trig #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] high,
  output logic             trig
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run;

  assign run = en && (period != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q >= period - ONE)
      cnt_d = '0;
    else
      cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trig = run && (cnt_q < high);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt_q >= period - ONE)) |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt_q < period - ONE)) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/ranger_echo_cap.sv
`timescale 1ns/1ps
module ranger_echo_cap #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic echo,
  input  logic clr,
  output logic pol,
  output logic pend,
  output logic ovr
);
  logic [SYNC_STAGES:0] chain_q, chain_d;
  logic cur, prev, rise, fall, edge_seen;
  logic pol_d, pend_d, ovr_d;

  assign chain_d   = {chain_q[SYNC_STAGES-1:0], echo};
  assign cur       = chain_q[SYNC_STAGES-1];
  assign prev      = chain_q[SYNC_STAGES];
  assign rise      = cur && !prev;
  assign fall      = !cur && prev;
  assign edge_seen = rise || fall;

  always_comb begin
    pol_d  = pol;
    pend_d = pend;
    ovr_d  = ovr;
    if (edge_seen) begin
      pol_d  = rise;
      pend_d = 1'b1;
    end else if (clr) begin
      pend_d = 1'b0;
    end
    if (clr)
      ovr_d = 1'b0;
    else if (edge_seen && pend)
      ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      pol     <= 1'b0;
      pend    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      chain_q <= chain_d;
      pol     <= pol_d;
      pend    <= pend_d;
      ovr     <= ovr_d;
    end
  end

  p_edge_sets_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> pend);
  p_pend_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
  p_pol_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |=> $stable(pol));
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && edge_seen && !clr) |=> ovr);
  p_coincide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && clr) |=> (pend && !ovr));
  p_one_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
endmodule

// File: rtl/echo_ranger.sv
`timescale 1ns/1ps
module echo_ranger
  import ranger_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              echo_i,
  output logic              trig_o,
  output logic              irq_o
);
  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             en_q, en_d;
  logic [CNT_W-1:0] period_q, period_d, high_q, high_d;
  logic             clr_pulse;
  logic             st_pol, st_pend, st_ovr;
  reg_addr_e        addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign addr      = reg_addr_e'(bus_addr);
  assign clr_pulse = bus_wr && (addr == ADR_STATUS) && bus_wdata[STAT_CLR_BIT];

  always_comb begin
    en_d     = en_q;
    period_d = period_q;
    high_d   = high_q;
    if (bus_wr) begin
      case (addr)
        ADR_CTRL:   en_d     = bus_wdata[CTRL_EN_BIT];
        ADR_PERIOD: period_d = bus_wdata;
        ADR_HIGH:   high_d   = bus_wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q     <= 1'b0;
      period_q <= '0;
      high_q   <= '0;
    end else begin
      en_q     <= en_d;
      period_q <= period_d;
      high_q   <= high_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr)
      ADR_CTRL:   bus_rdata[CTRL_EN_BIT] = en_q;
      ADR_PERIOD: bus_rdata = period_q;
      ADR_HIGH:   bus_rdata = high_q;
      ADR_STATUS: begin
        bus_rdata[ST_POL_BIT]  = st_pol;
        bus_rdata[ST_PEND_BIT] = st_pend;
        bus_rdata[ST_OVR_BIT]  = st_ovr;
      end
      default:    bus_rdata = '0;
    endcase
  end

  ranger_trig #(.CNT_W(CNT_W)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en     (en_q),
    .period (period_q),
    .high   (high_q),
    .trig   (trig_o)
  );

  ranger_echo_cap #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk   (clk),
    .rst_n (rst_n_s),
    .echo  (echo_i),
    .clr   (clr_pulse),
    .pol   (st_pol),
    .pend  (st_pend),
    .ovr   (st_ovr)
  );

  assign irq_o = st_pend;

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_o && !clr_pulse) |=> irq_o);
  p_period_zero_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(period_q) == '0 && period_q == '0) |-> !trig_o);
endmodule

// File: tb/test_echo_ranger.sv
`timescale 1ns/1ps
module test_echo_ranger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        echo_i;
  logic        trig_o;
  logic        irq_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  echo_ranger i_echo_ranger (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .echo_i(echo_i),
    .trig_o(trig_o), .irq_o(irq_o)
  );

  // {period, high}
  localparam logic [31:0] VECS [0:4] = '{
    {16'd5, 16'd2}, {16'd8, 16'd1}, {16'd3, 16'd2}, {16'd2, 16'd1}, {16'd4, 16'd0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; echo_i = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "trig", trig_o, 0);
    check("R1", "irq", irq_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1", "reg", d, 0);
    end

    // R10 readback
    wr(2'd1, 16'h1234); wr(2'd2, 16'h0042); wr(2'd0, 16'hFFFE);
    rd(2'd1, d); check("R10", "period", d, 16'h1234);
    rd(2'd2, d); check("R10", "high", d, 16'h0042);
    rd(2'd0, d); check("R10", "ctrl bit0 only", d, 0);

    // R2 vector table walk
    for (int v = 0; v < 5; v++) begin
      int per, hi;
      per = int'(VECS[v][31:16]);
      hi  = int'(VECS[v][15:0]);
      wr(2'd1, VECS[v][31:16]);
      wr(2'd2, VECS[v][15:0]);
      wr(2'd0, 16'd1);
      for (int i = 0; i < 2 * per + 1; i++) begin
        check("R2", "trig wave", trig_o, ((i % per) < hi) ? 1 : 0);
        @(negedge clk);
      end
      wr(2'd0, 16'd0);
      check("R4", "trig after disable", trig_o, 0);
    end

    // R3 zero period
    wr(2'd1, 16'd0); wr(2'd2, 16'd3); wr(2'd0, 16'd1);
    for (int i = 0; i < 10; i++) begin
      check("R3", "trig with zero period", trig_o, 0);
      @(negedge clk);
    end
    wr(2'd0, 16'd0);

    // R4 disable mid-high, restart from zero
    wr(2'd1, 16'd6); wr(2'd2, 16'd3); wr(2'd0, 16'd1);
    @(negedge clk);
    check("R4", "trig mid high", trig_o, 1);
    wr(2'd0, 16'd0);
    check("R4", "trig forced low", trig_o, 0);
    repeat (3) @(negedge clk);
    check("R4", "trig stays low", trig_o, 0);
    wr(2'd0, 16'd1);
    for (int i = 0; i < 6; i++) begin
      check("R4", "restart wave", trig_o, (i < 3) ? 1 : 0);
      @(negedge clk);
    end
    wr(2'd0, 16'd0);

    // R5 rising edge
    echo_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R5", "irq not yet", irq_o, 0);
    @(negedge clk);
    check("R5", "irq after rise", irq_o, 1);
    rd(2'd3, d); check("R5", "status rise", d, 16'h3);

    // R7 write 0 ignored, then clear keeps polarity
    wr(2'd3, 16'd0);
    check("R7", "irq after zero write", irq_o, 1);
    rd(2'd3, d); check("R7", "status after zero write", d, 16'h3);
    wr(2'd3, 16'd1);
    check("R7", "irq cleared", irq_o, 0);
    rd(2'd3, d); check("R7", "polarity kept", d, 16'h1);

    // R6 falling edge
    echo_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", "irq after fall", irq_o, 1);
    rd(2'd3, d); check("R6", "status fall", d, 16'h2);

    // R8 overrun
    echo_i = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd3, d); check("R8", "overrun set", d, 16'h7);
    wr(2'd3, 16'd1);
    rd(2'd3, d); check("R8", "overrun cleared", d, 16'h1);

    // R9 coincident edge and clear
    echo_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd3, d); check("R9", "pending before", d, 16'h2);
    echo_i = 1'b1;
    repeat (2) @(negedge clk);
    bus_addr = 2'd3; bus_wdata = 16'd1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9", "irq kept", irq_o, 1);
    rd(2'd3, d); check("R9", "status coincide", d, 16'h3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule